// File: doc/BRIEF.md
# Seven-Channel Priority Transfer Arbiter

This block decides which of seven transfer channels moves its next single data item. Every channel brings an enable, a memory-to-memory mode flag, a two-bit urgency level, a flag saying its remaining item count is non-zero, a pending-fault flag and one peripheral request line. While no transfer is in flight, the arbiter looks at all channels that can be served and issues a one-hot grant to one of them. That grant stays in place until the datapath reports that the single read-then-write transfer has finished, either with a done pulse or with an error pulse. The arbiter then drops the grant and, on the next cycle, makes a fresh choice.

For channels that a peripheral paces, the arbiter also runs the four-phase request/acknowledge exchange. The acknowledge goes high together with the grant. It stays high as long as the peripheral keeps its request asserted, and it falls on the cycle after the request is removed. Channels in memory-to-memory mode need no peripheral. They count as requesting for as long as they are enabled and have items left. Such a channel gives way to any other waiting channel after each of its items, so a long memory copy cannot lock out a peripheral whose level is lower.

The grant is the only downstream interface, and its back-pressure rule is simple: the datapath holds the arbiter back by not pulsing done or error, and the grant does not change in the meantime. There is no other stall path.

Top module: `dma_chan_arbiter`

## Requirements
- R1: Each channel's level field uses the code 00 for low, 01 for medium, 10 for high and 11 for the top level. Among the channels that can be served, one with a strictly higher level always wins.
- R2: When the best candidates share a level, the channel with the lowest index wins.
- R3: At most one grant bit is set at any time. A grant stays unchanged until a cycle in which xfer_done or xfer_error is high. On that edge it clears, and xfer_error releases the grant in the same way as xfer_done.
- R4: After a grant clears there is exactly one cycle with no grant. If a candidate exists in that cycle, the next grant is present on the cycle after it.
- R5: Once a memory-to-memory channel's transfer ends, the next grant goes to another candidate if one exists, even when that candidate's level is lower.
- R6: Only a channel that is enabled, has no pending fault and has a non-zero count is ever granted. A disabled, faulted or empty channel gets no grant, whether or not its request is asserted.
- R7: For a channel not in memory-to-memory mode, periph_ack rises in the same cycle as that channel's grant. It stays high while periph_req stays high, and it falls one cycle after periph_req falls.
- R8: A peripheral channel whose acknowledge is still high is not a candidate, so a request that stays asserted is served only once.
- R9: A memory-to-memory channel receives grant after grant with no peripheral request. Its acknowledge is never raised.
- R10: While reset is held, and just after it is released, all grant and acknowledge outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_enable | input | 7 | Per-channel enable |
| ch_mem2mem | input | 7 | Per-channel memory-to-memory mode |
| ch_count_nz | input | 7 | Per-channel remaining item count is non-zero |
| ch_fault | input | 7 | Per-channel pending transfer error |
| ch_level | input | 14 | Per-channel 2-bit level; channel i occupies bits [2i+1:2i] |
| periph_req | input | 7 | Per-channel peripheral request |
| periph_ack | output | 7 | Per-channel peripheral acknowledge |
| xfer_grant | output | 7 | One-hot grant for a single-item transfer |
| xfer_done | input | 1 | Datapath pulse: the granted transfer completed |
| xfer_error | input | 1 | Datapath pulse: the granted transfer failed |

## Verification
The hardest behaviour to reach is the memory-to-memory deferral. It shows up only when a top-level copy channel and a lower-level peripheral are both candidates at the moment the copy channel's transfer finishes. The stimulus holds the peripheral request high through the whole copy and then checks that the grants alternate, copy, peripheral, copy. A second case is a request held high after its transfer. The stimulus leaves that request asserted for several idle cycles to show the channel is not served a second time, then lowers it to watch the acknowledge fall exactly one cycle later.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MED  = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_TOP  = 2'b11
  } arb_level_e;
endpackage

// File: rtl/dma_arb_elig.sv
module dma_arb_elig #(
  parameter int NUM_CH = 7
) (
  input  logic [NUM_CH-1:0] ch_enable,
  input  logic [NUM_CH-1:0] ch_mem2mem,
  input  logic [NUM_CH-1:0] ch_count_nz,
  input  logic [NUM_CH-1:0] ch_fault,
  input  logic [NUM_CH-1:0] periph_req,
  input  logic [NUM_CH-1:0] periph_ack,
  input  logic [NUM_CH-1:0] defer_mask,
  output logic [NUM_CH-1:0] cand
);
  logic [NUM_CH-1:0] raw;
  logic [NUM_CH-1:0] others;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic active;
    logic wants;
    // serviceable: enabled, fault-free, items left
    assign active = ch_enable[i] & ~ch_fault[i] & ch_count_nz[i];
    // copy channels request on their own; peripherals need a fresh request
    assign wants  = ch_mem2mem[i] | (periph_req[i] & ~periph_ack[i]);
    assign raw[i] = active & wants;
  end

  // a deferred copy channel yields only if someone else is waiting
  assign others = raw & ~defer_mask;
  assign cand   = (|others) ? others : raw;
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
  parameter int NUM_CH = 7,
  parameter int LVL_W  = 2
) (
  input  logic [NUM_CH-1:0]       cand,
  input  logic [NUM_CH*LVL_W-1:0] level,
  output logic [NUM_CH-1:0]       pick_oh,
  output logic                    pick_any
);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [LVL_W-1:0] best_lvl;
  logic [IDX_W-1:0] best_idx;
  logic             found;

  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    found    = 1'b0;
    // strict compare keeps the lowest index on a tie
    for (int i = 0; i < NUM_CH; i++) begin
      if (cand[i] && (!found || level[i*LVL_W +: LVL_W] > best_lvl)) begin
        best_lvl = level[i*LVL_W +: LVL_W];
        best_idx = IDX_W'(i);
        found    = 1'b1;
      end
    end
    pick_oh = '0;
    if (found) pick_oh[best_idx] = 1'b1;
    pick_any = found;
  end
endmodule

// File: rtl/dma_arb_handshake.sv
module dma_arb_handshake #(
  parameter int NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] grant_fire,
  input  logic [NUM_CH-1:0] ch_mem2mem,
  input  logic [NUM_CH-1:0] periph_req,
  output logic [NUM_CH-1:0] periph_ack
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ack
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        periph_ack[i] <= 1'b0;
      else if (grant_fire[i] && !ch_mem2mem[i])
        periph_ack[i] <= 1'b1;
      else if (!periph_req[i])
        periph_ack[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter #(
  parameter int NUM_CH = 7,
  parameter int LVL_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       ch_enable,
  input  logic [NUM_CH-1:0]       ch_mem2mem,
  input  logic [NUM_CH-1:0]       ch_count_nz,
  input  logic [NUM_CH-1:0]       ch_fault,
  input  logic [NUM_CH*LVL_W-1:0] ch_level,
  input  logic [NUM_CH-1:0]       periph_req,
  output logic [NUM_CH-1:0]       periph_ack,
  output logic [NUM_CH-1:0]       xfer_grant,
  input  logic                    xfer_done,
  input  logic                    xfer_error
);
  logic [NUM_CH-1:0] cand;
  logic [NUM_CH-1:0] pick_oh;
  logic              pick_any;
  logic [NUM_CH-1:0] grant_q;
  logic [NUM_CH-1:0] defer_q;
  logic [NUM_CH-1:0] fire;
  logic              idle;
  logic              finish;

  assign idle   = ~|grant_q;
  assign finish = ~idle & (xfer_done | xfer_error);
  assign fire   = (idle & pick_any) ? pick_oh : '0;

  dma_arb_elig #(.NUM_CH(NUM_CH)) u_elig (
    .ch_enable   (ch_enable),
    .ch_mem2mem  (ch_mem2mem),
    .ch_count_nz (ch_count_nz),
    .ch_fault    (ch_fault),
    .periph_req  (periph_req),
    .periph_ack  (periph_ack),
    .defer_mask  (defer_q),
    .cand        (cand)
  );

  dma_arb_pick #(.NUM_CH(NUM_CH), .LVL_W(LVL_W)) u_pick (
    .cand     (cand),
    .level    (ch_level),
    .pick_oh  (pick_oh),
    .pick_any (pick_any)
  );

  dma_arb_handshake #(.NUM_CH(NUM_CH)) u_hs (
    .clk        (clk),
    .rst_n      (rst_n),
    .grant_fire (fire),
    .ch_mem2mem (ch_mem2mem),
    .periph_req (periph_req),
    .periph_ack (periph_ack)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      defer_q <= '0;
    end else if (idle && pick_any) begin
      grant_q <= pick_oh;
      defer_q <= '0;
    end else if (finish) begin
      grant_q <= '0;
      defer_q <= grant_q & ch_mem2mem;
    end
  end

  assign xfer_grant = grant_q;
endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker #(
  parameter int NUM_CH = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] ch_enable,
  input logic [NUM_CH-1:0] ch_mem2mem,
  input logic [NUM_CH-1:0] ch_count_nz,
  input logic [NUM_CH-1:0] ch_fault,
  input logic [NUM_CH-1:0] periph_req,
  input logic [NUM_CH-1:0] periph_ack,
  input logic [NUM_CH-1:0] xfer_grant,
  input logic              xfer_done,
  input logic              xfer_error
);
  assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(xfer_grant));

  assert_grant_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_grant != '0 && !xfer_done && !xfer_error) |=> xfer_grant == $past(xfer_grant));

  assert_grant_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_grant != '0 && (xfer_done || xfer_error)) |=> xfer_grant == '0);

  assert_grant_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_grant != '0 && $past(xfer_grant) == '0) |->
      ((xfer_grant & $past(ch_enable & ~ch_fault & ch_count_nz)) != '0));

  assert_ack_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(periph_ack & periph_req)) |=>
      ((periph_ack & $past(periph_ack & periph_req)) == $past(periph_ack & periph_req)));

  assert_ack_with_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((periph_ack & ~$past(periph_ack)) & ~xfer_grant) == '0);

  assert_no_copy_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((periph_ack & ~$past(periph_ack)) & $past(ch_mem2mem)) == '0);
endmodule

bind dma_chan_arbiter dma_arb_checker #(.NUM_CH(NUM_CH)) u_arb_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ch_enable   (ch_enable),
  .ch_mem2mem  (ch_mem2mem),
  .ch_count_nz (ch_count_nz),
  .ch_fault    (ch_fault),
  .periph_req  (periph_req),
  .periph_ack  (periph_ack),
  .xfer_grant  (xfer_grant),
  .xfer_done   (xfer_done),
  .xfer_error  (xfer_error)
);

// File: tb/dma_chan_arbiter_test.sv
module dma_chan_arbiter_test;
  localparam int N = 7;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] en = '0, m2m = '0, cnt = '0, flt = '0, req = '0;
  logic [2*N-1:0] lvl = '0;
  logic [N-1:0] ack, grant;
  logic         done = 1'b0, err = 1'b0;
  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  dma_chan_arbiter uut (
    .clk(clk), .rst_n(rst_n), .ch_enable(en), .ch_mem2mem(m2m),
    .ch_count_nz(cnt), .ch_fault(flt), .ch_level(lvl), .periph_req(req),
    .periph_ack(ack), .xfer_grant(grant), .xfer_done(done), .xfer_error(err)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setup(input int ch, input logic [1:0] l, input logic copy);
    en[ch] = 1'b1; cnt[ch] = 1'b1; lvl[ch*2 +: 2] = l; m2m[ch] = copy;
  endtask

  task automatic clear_all();
    en = '0; m2m = '0; cnt = '0; flt = '0; req = '0; lvl = '0;
    done = 1'b0; err = 1'b0;
    repeat (3) tick();
  endtask

  task automatic get_grant(output logic [N-1:0] g);
    g = '0;
    for (int k = 0; k < 16; k++) begin
      tick();
      if (grant != '0) begin
        g = grant;
        break;
      end
    end
  endtask

  task automatic pulse_done();
    done = 1'b1; tick(); done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 grant in reset", 32'(grant), 0);
    chk("R10 ack in reset", 32'(ack), 0);
    tick(); rst_n = 1'b1; tick();
    chk("R10 grant after reset", 32'(grant), 0);
    chk("R10 ack after reset", 32'(ack), 0);
  endtask

  task automatic t_priority();
    logic [N-1:0] g;
    setup(0, 2'b00, 1'b0); setup(2, 2'b01, 1'b0); setup(5, 2'b11, 1'b0);
    req = 7'b0100101;
    get_grant(g);
    chk("R1 top level wins", 32'(g), 32'h20);
    chk("R7 ack with grant", 32'(ack), 32'h20);
    pulse_done();
    chk("R4 idle cycle after done", 32'(grant), 0);
    tick();
    chk("R4 next grant one cycle later", 32'(grant), 32'h04);
    chk("R8 held request not reserved", 32'(grant), 32'h04);
    pulse_done();
    get_grant(g);
    chk("R1 low level last", 32'(g), 32'h01);
    pulse_done();
    repeat (5) tick();
    chk("R8 no grant while acks held", 32'(grant), 0);
    chk("R7 acks held with requests", 32'(ack), 32'h25);
    req = '0; tick();
    chk("R7 ack falls one cycle after request", 32'(ack), 0);
    clear_all();
  endtask

  task automatic t_tie();
    logic [N-1:0] g;
    setup(6, 2'b10, 1'b0); setup(3, 2'b10, 1'b0);
    req = 7'b1001000;
    get_grant(g);
    chk("R2 lower index wins tie", 32'(g), 32'h08);
    pulse_done();
    get_grant(g);
    chk("R2 other tied channel next", 32'(g), 32'h40);
    pulse_done(); req = '0;
    clear_all();
  endtask

  task automatic t_hold_and_error();
    logic [N-1:0] g;
    setup(4, 2'b01, 1'b0); setup(1, 2'b11, 1'b1);
    en[1] = 1'b0;
    req[4] = 1'b1;
    get_grant(g);
    chk("R3 grant issued", 32'(g), 32'h10);
    en[1] = 1'b1;
    repeat (6) tick();
    chk("R3 grant held without done", 32'(grant), 32'h10);
    err = 1'b1; tick(); err = 1'b0;
    chk("R3 error releases grant", 32'(grant), 0);
    en[1] = 1'b0; req = '0;
    clear_all();
  endtask

  task automatic t_copy();
    logic [N-1:0] g;
    setup(1, 2'b11, 1'b1); setup(4, 2'b00, 1'b0);
    req[4] = 1'b1;
    get_grant(g);
    chk("R5 copy channel first", 32'(g), 32'h02);
    chk("R9 no ack for copy channel", 32'(ack), 0);
    pulse_done();
    get_grant(g);
    chk("R5 lower peripheral served after copy", 32'(g), 32'h10);
    pulse_done();
    get_grant(g);
    chk("R5 copy channel resumes", 32'(g), 32'h02);
    req[4] = 1'b0;
    pulse_done();
    get_grant(g);
    chk("R9 copy channel requests continuously", 32'(g), 32'h02);
    chk("R9 copy ack stays low", 32'(ack), 0);
    en[1] = 1'b0;
    pulse_done();
    repeat (3) tick();
    chk("R6 disabled copy channel idle", 32'(grant), 0);
    clear_all();
  endtask

  task automatic t_inactive();
    logic [N-1:0] g;
    en[0] = 1'b1; req[0] = 1'b1; cnt[0] = 1'b0;
    en[2] = 1'b1; m2m[2] = 1'b1; cnt[2] = 1'b0;
    repeat (4) tick();
    chk("R6 empty channels not served", 32'(grant), 0);
    cnt[0] = 1'b1; flt[0] = 1'b1;
    repeat (4) tick();
    chk("R6 faulted channel not served", 32'(grant), 0);
    flt[0] = 1'b0; en[0] = 1'b0;
    repeat (4) tick();
    chk("R6 disabled channel not served", 32'(grant), 0);
    en[0] = 1'b1;
    get_grant(g);
    chk("R6 active channel served", 32'(g), 32'h01);
    pulse_done(); req = '0;
    clear_all();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    tick();
    t_reset();
    t_priority();
    t_tie();
    t_hold_and_error();
    t_copy();
    t_inactive();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule